// File: doc/BRIEF.md
# Station Address Filter

This block decides whether an Ethernet frame is addressed to this station. A host loads a small table of 48-bit station addresses through a 16-bit write port and sets an enable bit for each entry. Frame bytes then arrive one per valid strobe after a frame-start strobe. A mode flag sampled with that strobe selects which address field is captured. With the flag low (ordinary reception or loopback) the destination field is captured. With the flag high (the station hearing its own transmission) the source field is captured.

Once the six bytes of the chosen field are in, the captured address is compared against every enabled entry in parallel, and also against a fixed all-ones broadcast entry. The block then posts a one-cycle result. The result carries a table-hit flag, the index of the lowest matching entry, a separate broadcast flag, and a reject pulse for frames that matched nothing. Receive control logic uses the reject pulse to drop the frame.

Top module: `stn_addr_filter`

## Requirements
- R1: After reset `res_vld` and `reject` are low, `hit`, `hit_idx` and `bcast_hit` are 0, and every table entry is disabled.
- R2: A table entry is written in three host cycles with `host_wr` high. `host_sel` value 0 stages address bits [15:0], value 1 stages bits [31:16], and value 2 supplies bits [47:32] and commits all 48 bits to entry `host_entry`. Select value 3 is ignored. Writing selects 0 and 1 alone leaves the entry unchanged.
- R3: A cycle with `en_load` high replaces the enable vector with `en_bits`, where bit i enables entry i. An entry whose enable bit is 0 never matches.
- R4: With `self_rx` low at the frame-start strobe, frame bytes 0 to 5 are captured as the address, least significant byte first. Frame byte k lands in address bits [8k+7:8k].
- R5: With `self_rx` high at the frame-start strobe, frame bytes 6 to 11 are captured instead, in the same byte order.
- R6: `res_vld` is high for exactly one cycle per frame. That cycle is the second cycle after the cycle that carries the last byte of the captured field.
- R7: When several enabled entries match, `hit` is 1 and `hit_idx` is the lowest matching index. When no entry matches, `hit` and `hit_idx` are 0.
- R8: A captured address of all ones sets `bcast_hit` whatever the enables are. Any other address clears it.
- R9: `reject` pulses together with `res_vld` when neither a table entry nor the broadcast entry matched. It stays low in every other cycle.
- R10: Byte cycles with `byte_vld` low are skipped without changing the capture. Bytes seen after reset but before any frame-start strobe produce no result.
- R11: Group addresses, which have bit 0 of the first byte set, are stored and matched exactly like individual addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host table write strobe |
| host_entry | input | 4 | Entry being written |
| host_sel | input | 2 | Word select, 0 = low, 1 = middle, 2 = high and commit |
| host_data | input | 16 | Address word |
| en_load | input | 1 | Load the enable vector |
| en_bits | input | 16 | New enable vector, one bit per entry |
| frm_start | input | 1 | Frame-start strobe, carries no byte |
| self_rx | input | 1 | Field select sampled with frm_start: 1 = source, 0 = destination |
| byte_vld | input | 1 | Frame byte valid |
| byte_data | input | 8 | Frame byte |
| res_vld | output | 1 | One-cycle result strobe |
| hit | output | 1 | A programmable entry matched |
| hit_idx | output | 4 | Lowest matching entry |
| bcast_hit | output | 1 | Broadcast entry matched |
| reject | output | 1 | Frame matched nothing |

## Verification
The same frame is sent once with the mode flag low and once with it high. The destination and source fields carry different addresses, so only the right field choice gives the expected index. Frames whose bytes have idle gaps show that skipped cycles leave the capture intact. A byte-reversed copy of a stored address must be rejected, which exposes a wrong byte order. Overlapping entries are enabled and disabled in turn to check the lowest-index rule and the enables. A half-finished host write followed by the committing word separates staged words from committed ones. The all-ones address shows the broadcast flag is independent of the table.

// File: rtl/stn_filt_pkg.sv
package stn_filt_pkg;

    localparam int NUM_ENTRIES = 16;
    localparam int ADDR_BYTES  = 6;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = ADDR_BYTES * BYTE_W;
    localparam int HOST_W      = 16;
    localparam int IDX_W       = $clog2(NUM_ENTRIES);
    localparam int SEL_W       = 2;
    localparam int FRAME_LIM   = 2 * ADDR_BYTES;
    localparam int CNT_W       = $clog2(FRAME_LIM + 1);

    typedef logic [ADDR_W-1:0] mac_t;

    typedef enum logic {
        FLD_DEST = 1'b0,
        FLD_SRC  = 1'b1
    } field_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             bcast;
    } match_t;

    localparam mac_t BCAST_ADDR = '1;

    function automatic logic [IDX_W-1:0] lowest_idx(input logic [NUM_ENTRIES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/addr_capture.sv
module addr_capture
    import stn_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              self_rx,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output mac_t              addr,
    output logic              done
);
    localparam logic [CNT_W-1:0] LIM      = CNT_W'(FRAME_LIM);
    localparam logic [CNT_W-1:0] SRC_BASE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0] pos;
    field_e           fld;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] off;
    logic             in_field;

    always_comb begin
        base     = (fld == FLD_SRC) ? SRC_BASE : '0;
        last     = base + LAST_OFF;
        off      = pos - base;
        in_field = (pos >= base) && (pos <= last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= LIM;
            fld  <= FLD_DEST;
            addr <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (frm_start) begin
                pos <= '0;
                fld <= field_e'(self_rx);
            end else if (byte_vld && (pos != LIM)) begin
                pos <= pos + CNT_W'(1);
                if (in_field) begin
                    addr[BYTE_W*off +: BYTE_W] <= byte_data;
                end
                done <= (pos == last);
            end
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_pos_bound_r10: assert property (@(posedge clk) disable iff (rst)
        pos <= LIM);

    p_done_needs_byte_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(byte_vld));

endmodule

// File: rtl/cam_table.sv
module cam_table
    import stn_filt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_wr,
    input  logic [IDX_W-1:0]       host_entry,
    input  logic [SEL_W-1:0]       host_sel,
    input  logic [HOST_W-1:0]      host_data,
    input  logic                   en_load,
    input  logic [NUM_ENTRIES-1:0] en_bits,
    input  mac_t                   key,
    output logic [NUM_ENTRIES-1:0] match_vec
);
    localparam logic [SEL_W-1:0] SEL_LO  = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_MID = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_HI  = SEL_W'(2);

    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] entries;
    logic [NUM_ENTRIES-1:0]             en_q;
    logic [HOST_W-1:0]                  stage_lo;
    logic [HOST_W-1:0]                  stage_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            entries   <= '0;
            en_q      <= '0;
            stage_lo  <= '0;
            stage_mid <= '0;
        end else begin
            if (en_load) en_q <= en_bits;
            if (host_wr) begin
                case (host_sel)
                    SEL_LO:  stage_lo  <= host_data;
                    SEL_MID: stage_mid <= host_data;
                    SEL_HI:  entries[host_entry] <= {host_data, stage_mid, stage_lo};
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = en_q[g] && (entries[g] == key);
    end

    p_commit_only_hi_r2: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_sel == SEL_HI) |=> $stable(entries));

    p_disabled_no_match_r3: assert property (@(posedge clk) disable iff (rst)
        (match_vec & ~en_q) == '0);

endmodule

// File: rtl/stn_addr_filter.sv
module stn_addr_filter
    import stn_filt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_wr,
    input  logic [IDX_W-1:0]       host_entry,
    input  logic [SEL_W-1:0]       host_sel,
    input  logic [HOST_W-1:0]      host_data,
    input  logic                   en_load,
    input  logic [NUM_ENTRIES-1:0] en_bits,
    input  logic                   frm_start,
    input  logic                   self_rx,
    input  logic                   byte_vld,
    input  logic [BYTE_W-1:0]      byte_data,
    output logic                   res_vld,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx,
    output logic                   bcast_hit,
    output logic                   reject
);
    mac_t                   cap_addr;
    logic                   cap_done;
    logic [NUM_ENTRIES-1:0] match_vec;
    match_t                 res_q;
    match_t                 res_d;

    addr_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .self_rx   (self_rx),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .addr      (cap_addr),
        .done      (cap_done)
    );

    cam_table u_cam (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_entry (host_entry),
        .host_sel   (host_sel),
        .host_data  (host_data),
        .en_load    (en_load),
        .en_bits    (en_bits),
        .key        (cap_addr),
        .match_vec  (match_vec)
    );

    always_comb begin
        res_d.hit   = |match_vec;
        res_d.idx   = lowest_idx(match_vec);
        res_d.bcast = (cap_addr == BCAST_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            res_vld <= 1'b0;
            reject  <= 1'b0;
        end else begin
            res_vld <= cap_done;
            reject  <= cap_done && !res_d.hit && !res_d.bcast;
            if (cap_done) res_q <= res_d;
        end
    end

    assign hit       = res_q.hit;
    assign hit_idx   = res_q.idx;
    assign bcast_hit = res_q.bcast;

    p_reject_excl_r9: assert property (@(posedge clk) disable iff (rst)
        reject |-> (res_vld && !hit && !bcast_hit));

    p_vld_timing_r6: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> $past(cap_done));

    p_idx_zero_on_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !hit) |-> (hit_idx == '0));

endmodule

// File: tb/stn_addr_filter_test.sv
module stn_addr_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [3:0]  host_entry = '0;
    logic [1:0]  host_sel = '0;
    logic [15:0] host_data = '0;
    logic        en_load = 1'b0;
    logic [15:0] en_bits = '0;
    logic        frm_start = 1'b0;
    logic        self_rx = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        res_vld, hit, bcast_hit, reject;
    logic [3:0]  hit_idx;

    stn_addr_filter uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_entry(host_entry),
        .host_sel(host_sel), .host_data(host_data), .en_load(en_load),
        .en_bits(en_bits), .frm_start(frm_start), .self_rx(self_rx),
        .byte_vld(byte_vld), .byte_data(byte_data), .res_vld(res_vld),
        .hit(hit), .hit_idx(hit_idx), .bcast_hit(bcast_hit), .reject(reject)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        hit;
        logic [3:0]  idx;
        logic        bc;
        logic        rej;
        int unsigned cyc;
    } exp_t;

    exp_t        q[$];
    int          errors = 0;
    int          checks = 0;
    int          res_seen = 0;
    int unsigned cyc = 0;
    logic [47:0] m_ent[16];
    logic [15:0] m_en = '0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each result strobe with the head of the scoreboard.
    always @(negedge clk) begin
        if (!rst && res_vld) begin
            res_seen++;
            if (q.size() == 0) begin
                check(0, "R6", "unexpected result strobe", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.cyc, "R6", "result cycle", cyc, e.cyc);
                check(hit == e.hit && hit_idx == e.idx, "R7", "hit/idx",
                      {hit, hit_idx}, {e.hit, e.idx});
                check(bcast_hit == e.bc, "R8", "broadcast flag", bcast_hit, e.bc);
                check(reject == e.rej, "R9", "reject", reject, e.rej);
            end
        end else if (!rst && reject) begin
            check(0, "R9", "reject without result strobe", 1, 0);
        end
    end

    task automatic host_word(input logic [3:0] idx, input logic [1:0] sel,
                             input logic [15:0] d);
        host_wr = 1'b1; host_entry = idx; host_sel = sel; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // R2: full three-word write
    task automatic load_entry(input logic [3:0] idx, input logic [47:0] a);
        host_word(idx, 2'd0, a[15:0]);
        host_word(idx, 2'd1, a[31:16]);
        host_word(idx, 2'd2, a[47:32]);
        m_ent[idx] = a;
    endtask

    // R3: enable vector
    task automatic set_en(input logic [15:0] v);
        en_load = 1'b1; en_bits = v;
        @(negedge clk);
        en_load = 1'b0;
        m_en = v;
    endtask

    function automatic exp_t predict(input logic [47:0] a, input int unsigned c);
        exp_t e;
        e = '0;
        for (int i = 15; i >= 0; i--) begin
            if (m_en[i] && m_ent[i] == a) begin
                e.hit = 1'b1;
                e.idx = 4'(i);
            end
        end
        e.bc  = (a == '1);
        e.rej = !e.hit && !e.bc;
        e.cyc = c;
        return e;
    endfunction

    // Driver: pushes the expected result when the last field byte is driven.
    task automatic send_frame(input bit src_mode, input logic [47:0] dst,
                              input logic [47:0] src, input bit gaps);
        int last;
        last = src_mode ? 11 : 5;
        frm_start = 1'b1; self_rx = src_mode;
        @(negedge clk);
        frm_start = 1'b0; self_rx = 1'b0;
        for (int k = 0; k < 14; k++) begin
            byte_vld  = 1'b1;
            byte_data = (k < 6) ? dst[8*k +: 8] : (k < 12) ? src[8*(k-6) +: 8] : 8'h55;
            if (k == last) q.push_back(predict(src_mode ? src : dst, cyc + 2));
            @(negedge clk);
            if (gaps) begin
                byte_vld = 1'b0; byte_data = 8'hA5;
                @(negedge clk);
            end
        end
        byte_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    localparam logic [47:0] ADR_A = 48'h0A_1B_2C_3D_4E_5F;
    localparam logic [47:0] ADR_B = 48'h60_71_82_93_A4_B6;
    localparam logic [47:0] ADR_C = 48'h00_00_00_00_00_10;
    localparam logic [47:0] ADR_D = 48'h12_34_56_78_9A_BC;
    localparam logic [47:0] ADR_E = 48'hDE_AD_BE_EF_00_02;
    localparam logic [47:0] ADR_M = 48'h00_00_5E_00_00_01;
    localparam logic [47:0] ADR_AR = 48'h5F_4E_3D_2C_1B_0A;

    initial begin
        int seen0;
        for (int i = 0; i < 16; i++) m_ent[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(res_vld == 0 && reject == 0, "R1", "strobes after reset", {res_vld, reject}, 0);
        check(hit == 0 && hit_idx == 0 && bcast_hit == 0, "R1", "result after reset",
              {hit, hit_idx, bcast_hit}, 0);

        // R10: bytes before any frame start give no result
        seen0 = res_seen;
        for (int k = 0; k < 14; k++) begin
            byte_vld = 1'b1; byte_data = 8'hFF;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        repeat (4) @(negedge clk);
        check(res_seen == seen0, "R10", "no result before frame start", res_seen, seen0);

        // R1: table empty and disabled after reset -> reject
        send_frame(0, ADR_A, ADR_B, 0);

        load_entry(4'd3, ADR_A);
        load_entry(4'd7, ADR_B);
        set_en(16'h0088);
        send_frame(0, ADR_A, ADR_C, 0);       // R4: idx 3
        send_frame(0, ADR_B, ADR_C, 1);       // R10: gaps, idx 7
        send_frame(1, ADR_C, ADR_B, 0);       // R5: source field, idx 7
        send_frame(0, ADR_C, ADR_B, 0);       // R4: dest field, reject
        send_frame(0, ADR_AR, ADR_C, 0);      // R4: byte order reversed, reject

        // R7: lowest index wins
        load_entry(4'd9, ADR_A);
        set_en(16'h0288);
        send_frame(0, ADR_A, ADR_C, 0);
        set_en(16'h0280);                     // R3: disable 3 -> idx 9
        send_frame(0, ADR_A, ADR_C, 0);

        // R3: programmed but disabled entry never matches
        load_entry(4'd5, ADR_D);
        send_frame(0, ADR_D, ADR_C, 0);

        // R8: broadcast independent of table
        send_frame(0, '1, ADR_C, 0);
        send_frame(1, ADR_C, '1, 1);

        // R2: partial write leaves entry intact
        host_word(4'd7, 2'd0, ADR_E[15:0]);
        host_word(4'd7, 2'd1, ADR_E[31:16]);
        host_word(4'd7, 2'd3, ADR_E[47:32]);  // select 3 ignored
        send_frame(0, ADR_B, ADR_C, 0);
        host_word(4'd7, 2'd2, ADR_E[47:32]);
        m_ent[7] = ADR_E;
        send_frame(0, ADR_E, ADR_C, 0);
        send_frame(0, ADR_B, ADR_C, 0);

        // R11: group address
        load_entry(4'd12, ADR_M);
        set_en(16'h1280);
        send_frame(0, ADR_M, ADR_C, 0);

        repeat (6) @(negedge clk);
        check(q.size() == 0, "R6", "all expected results arrived", q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule